// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Data Lookup

This block is the tag and data stage of a direct-mapped first-level data cache. The set is chosen from virtual-address bits that lie inside the page offset. Those bits never change under translation, so the line can be selected and read while the translation buffer is still working on the page number. One cycle after a request is accepted, the translated physical page number arrives with its own valid flag. The stored tag, which is a full physical page number, is compared against it, and the result is a hit or a miss.

A miss does not allocate anything. The block raises a miss flag and presents the full physical address of the access for the next cache level. That level later returns a whole line through the fill port, and the fill writes the tag, the data and the valid bit of the line picked by the physical address. While the translation is not ready, the pending lookup is held and no new request is taken. A flush input invalidates every line at once.

With the defaults, lines are 64 bytes, there are 256 sets, the page offset is 14 bits, the physical address is 40 bits and the stored tag is 26 bits. All of these follow from the parameters.

Top module: `vipt_l1_lookup`

## Requirements
- R1: After reset, `hit` and `miss` are low and `req_ready` is high. Every line is invalid, so the first lookup of any set reports a miss.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its result appears in the following cycle, once `tlb_valid` is high. With no new request, the result leaves after one edge.
- R3: The set is `req_va[13:6]` and `req_va[5:0]` is the byte within the 64-byte line. Lines at different sets hold independent tag, data and valid state.
- R4: A hit is reported when the selected line is valid and its stored tag equals `tlb_ppn`. On a hit, `rd_line` carries the 512-bit line.
- R5: A miss is reported when `tlb_valid` is high and the line is either invalid or holds a different physical page number. On a miss, `miss_paddr` equals {`tlb_ppn`, `req_va[13:0]`}, which is 40 bits.
- R6: `hit` and `miss` are never high together.
- R7: While a lookup is pending and `tlb_valid` is low, neither `hit` nor `miss` is raised and `req_ready` is low. The pending address is held, and the lookup completes in the first cycle where `tlb_valid` is high.
- R8: A fill writes into set `fill_line_addr[7:0]`. It stores tag `fill_line_addr[33:8]` (physical address bits 39:14), the data, and valid = 1. The line is visible from the next cycle.
- R9: `flush` clears every valid bit in one edge. When a fill arrives in the same cycle as a flush, the fill is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| req_va | input | 14 | Page-offset bits of the virtual address |
| tlb_valid | input | 1 | Translation of the pending lookup is available |
| tlb_ppn | input | 26 | Translated physical page number |
| hit | output | 1 | Pending lookup hits |
| miss | output | 1 | Pending lookup misses |
| rd_line | output | 512 | Data of the selected line |
| miss_paddr | output | 40 | Physical address for the next level on a miss |
| fill_valid | input | 1 | Line fill from the next level |
| fill_line_addr | input | 34 | Physical line address of the fill (address bits 39:6) |
| fill_data | input | 512 | Line data of the fill |
| flush | input | 1 | Invalidate all lines |

## Verification
The assertions assume that `tlb_ppn` stays stable while `tlb_valid` is high for a pending lookup. They also assume that a fill and a lookup to the same set never share a cycle, because read-during-fill ordering is left to the surrounding pipeline. The bench drives every input on the falling edge. It raises `tlb_valid` only for one cycle after a request has been accepted, drops `req_valid` before releasing a stalled translation, and keeps fills and lookups in separate cycles.

// File: rtl/vipt_l1_lookup.sv
module vipt_l1_lookup #(
  parameter int PA_W   = 40,
  parameter int PG_W   = 14,
  parameter int OFF_W  = 6,
  parameter int LINE_W = 512
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [PG_W-1:0]         req_va,
  input  logic                    tlb_valid,
  input  logic [PA_W-PG_W-1:0]    tlb_ppn,
  output logic                    hit,
  output logic                    miss,
  output logic [LINE_W-1:0]       rd_line,
  output logic [PA_W-1:0]         miss_paddr,
  input  logic                    fill_valid,
  input  logic [PA_W-OFF_W-1:0]   fill_line_addr,
  input  logic [LINE_W-1:0]       fill_data,
  input  logic                    flush
);
  localparam int IDX_W = PG_W - OFF_W;
  localparam int PPN_W = PA_W - PG_W;
  localparam int NSETS = 1 << IDX_W;

  logic              s1_valid;
  logic [PG_W-1:0]   s1_va;
  logic [IDX_W-1:0]  s1_idx;
  logic [IDX_W-1:0]  f_idx;
  logic [PPN_W-1:0]  f_tag;
  logic [NSETS-1:0]  valid_q;
  logic [PPN_W-1:0]  tag_mem  [NSETS];
  logic [LINE_W-1:0] data_mem [NSETS];
  logic              done, tag_eq;

  assign s1_idx = s1_va[PG_W-1:OFF_W];
  assign f_idx  = fill_line_addr[IDX_W-1:0];
  assign f_tag  = fill_line_addr[PA_W-OFF_W-1:IDX_W];

  assign req_ready  = !s1_valid || tlb_valid;
  assign done       = s1_valid && tlb_valid;
  assign tag_eq     = tag_mem[s1_idx] == tlb_ppn;
  assign hit        = done && valid_q[s1_idx] && tag_eq;
  assign miss       = done && !(valid_q[s1_idx] && tag_eq);
  assign rd_line    = data_mem[s1_idx];
  assign miss_paddr = {tlb_ppn, s1_va};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_va    <= '0;
    end else if (req_ready) begin
      s1_valid <= req_valid;
      if (req_valid) s1_va <= req_va;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                valid_q        <= '0;
    else if (flush)            valid_q        <= '0;
    else if (fill_valid)       valid_q[f_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_valid && !flush) begin
      tag_mem[f_idx]  <= f_tag;
      data_mem[f_idx] <= fill_data;
    end
  end

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit, miss})); // R6

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && !tlb_valid |=> s1_valid && $stable(s1_va)); // R7

  AST_RESULT_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (hit || miss) && !req_valid |=> !hit && !miss); // R2

  AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && !flush |=> valid_q[$past(f_idx)]); // R8

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> valid_q == '0); // R9
endmodule

// File: tb/tb_vipt_l1_lookup.sv
module tb_vipt_l1_lookup;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid;
  logic         req_ready;
  logic [13:0]  req_va;
  logic         tlb_valid;
  logic [25:0]  tlb_ppn;
  logic         hit, miss;
  logic [511:0] rd_line;
  logic [39:0]  miss_paddr;
  logic         fill_valid;
  logic [33:0]  fill_line_addr;
  logic [511:0] fill_data;
  logic         flush;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vipt_l1_lookup dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .tlb_valid(tlb_valid), .tlb_ppn(tlb_ppn), .hit(hit),
    .miss(miss), .rd_line(rd_line), .miss_paddr(miss_paddr),
    .fill_valid(fill_valid), .fill_line_addr(fill_line_addr),
    .fill_data(fill_data), .flush(flush)
  );

  function automatic logic [511:0] pat(input logic [31:0] s);
    return {16{s}};
  endfunction

  task automatic check(input string r, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic fill(input logic [25:0] ppn, input logic [7:0] idx, input logic [511:0] d);
    @(negedge clk);
    fill_valid = 1'b1; fill_line_addr = {ppn, idx}; fill_data = d;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic issue(input logic [13:0] va);
    @(negedge clk);
    req_valid = 1'b1; req_va = va;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic xlate(input logic [25:0] ppn);
    tlb_valid = 1'b1; tlb_ppn = ppn;
    #1;
  endtask

  task automatic xlate_end();
    @(negedge clk);
    tlb_valid = 1'b0;
  endtask

  task automatic lookup_expect(input string r, input logic [13:0] va, input logic [25:0] ppn,
                               input logic exp_hit, input logic [511:0] exp_data);
    issue(va);
    xlate(ppn);
    check(r, {510'b0, hit, miss}, {510'b0, exp_hit, !exp_hit});
    if (exp_hit) check(r, rd_line, exp_data);
    else         check(r, {472'b0, miss_paddr}, {472'b0, ppn, va});
    xlate_end();
    #1;
    check({r, " retire"}, {510'b0, hit, miss}, 512'b0);
  endtask

  task automatic t_reset();
    #1;
    check("R1 idle", {509'b0, hit, miss, req_ready}, 512'd1);
    lookup_expect("R1 cold miss", 14'h0140, 26'h0AB_CDE, 1'b0, '0);
  endtask

  task automatic t_hit_and_tag();
    fill(26'h123_4567, 8'h05, pat(32'hA5A5_0005));
    lookup_expect("R4 hit", {8'h05, 6'h11}, 26'h123_4567, 1'b1, pat(32'hA5A5_0005));
    lookup_expect("R5 tag mismatch", {8'h05, 6'h00}, 26'h123_4568, 1'b0, '0);
    lookup_expect("R2 back to back", {8'h05, 6'h3F}, 26'h123_4567, 1'b1, pat(32'hA5A5_0005));
  endtask

  task automatic t_index();
    fill(26'h000_0011, 8'hFF, pat(32'h0000_00FF));
    fill(26'h000_0022, 8'hFE, pat(32'h0000_00FE));
    lookup_expect("R3 top set", {8'hFF, 6'h2A}, 26'h000_0011, 1'b1, pat(32'h0000_00FF));
    lookup_expect("R3 neighbour set", {8'hFE, 6'h01}, 26'h000_0022, 1'b1, pat(32'h0000_00FE));
    lookup_expect("R3 wrong set", {8'hFE, 6'h01}, 26'h000_0011, 1'b0, '0);
    fill(26'h000_0033, 8'hFF, pat(32'h3333_3333));
    lookup_expect("R8 refill replaces", {8'hFF, 6'h00}, 26'h000_0033, 1'b1, pat(32'h3333_3333));
    lookup_expect("R8 old tag gone", {8'hFF, 6'h00}, 26'h000_0011, 1'b0, '0);
  endtask

  task automatic t_stall();
    issue({8'h05, 6'h08});
    for (int i = 0; i < 3; i++) begin
      #1;
      check("R7 stall no result", {510'b0, hit, miss}, 512'b0);
      check("R7 stall not ready", {511'b0, req_ready}, 512'b0);
      req_valid = 1'b1; req_va = {8'hFF, 6'h00};
      @(negedge clk);
    end
    req_valid = 1'b0;
    xlate(26'h123_4567);
    check("R7 released hit", {510'b0, hit, miss}, 512'd2);
    check("R7 held line", rd_line, pat(32'hA5A5_0005));
    check("R7 ready on xlate", {511'b0, req_ready}, 512'd1);
    xlate_end();
  endtask

  task automatic t_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    lookup_expect("R9 flushed", {8'h05, 6'h00}, 26'h123_4567, 1'b0, '0);
    lookup_expect("R9 flushed 2", {8'hFE, 6'h00}, 26'h000_0022, 1'b0, '0);
    @(negedge clk);
    flush = 1'b1; fill_valid = 1'b1; fill_line_addr = {26'h0000_077, 8'h10};
    fill_data = pat(32'h7777_7777);
    @(negedge clk);
    flush = 1'b0; fill_valid = 1'b0;
    lookup_expect("R9 flush beats fill", {8'h10, 6'h00}, 26'h0000_077, 1'b0, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_va = '0; tlb_valid = 1'b0; tlb_ppn = '0;
    fill_valid = 1'b0; fill_line_addr = '0; fill_data = '0; flush = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_hit_and_tag();
    t_index();
    t_stall();
    t_flush();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule